// File: doc/BRIEF.md
# Snooping I/O Coherence Controller

This block sits beside a direct-mapped data cache and watches every transfer that an I/O device makes over the shared memory bus. It holds its own copy of the cache's tags and valid bits. Snoop lookups therefore never compete with the processor's lookups in the main tag array. When a bus transfer hits a line held in the cache, the controller issues one command to the cache in the same cycle. For an incoming transfer it refreshes the line with the bus data. For an outgoing transfer it drops the line. If the cache is in write-back mode, the controller also drives the line's data onto the bus and holds memory off.

The processor side reports every line fill and every line invalidation to the controller, so the duplicate tags follow the main array. Lines are one data word wide. A word address splits into a line index (its low `IDX_W` bits) and a tag (the remaining high bits). The block decides its response combinationally from the bus inputs and the registered duplicate tags. Any change to the duplicate tags takes effect at the next clock edge.

Top module: `snoop_io_coherence`

## Requirements
- R1: After reset every duplicate entry is invalid, so no bus transfer produces a command until the processor side has filled a line.
- R2: A processor fill of word address A marks entry A[IDX_W-1:0] valid with tag A[ADDR_W-1:IDX_W] from the next cycle on.
- R3: A transfer with `bus_dir`=0 (device to memory) whose address hits raises `upd_valid` in the same cycle. With it, `upd_data` equals `bus_wdata` and `cmd_idx` equals the address index. `inv_valid` and `mem_inhibit` stay low in either mode, and the entry stays valid.
- R4: A transfer with `bus_dir`=1 (memory to device) that hits while `wb_mode`=0 (write-through) raises `inv_valid` in the same cycle, with `mem_inhibit` low and `supply_data` zero.
- R5: A transfer with `bus_dir`=1 that hits while `wb_mode`=1 (write-back) raises `mem_inhibit` and `inv_valid` in the same cycle. `supply_data` then equals `line_rd_data`, which is read at `line_rd_idx`. `line_rd_idx` always equals the bus address index.
- R6: When `bus_valid` is low, or the entry is invalid, or its tag differs, no command and no inhibit is raised and `supply_data` and `upd_data` are zero.
- R7: After a hit with `bus_dir`=1, the entry is invalid from the next cycle, so repeating the same transfer misses.
- R8: A processor invalidate of index I clears entry I from the next cycle on.
- R9: `cpu_stall` is high exactly when `cpu_wr_valid` is high, a snoop command is raised, and `cpu_wr_idx` equals `cmd_idx`.
- R10: When a fill and a snoop invalidation target the same index in one cycle, the fill's tag and valid bit are what remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | An I/O transfer is on the bus this cycle |
| bus_dir | input | 1 | 0: device to memory, 1: memory to device |
| bus_addr | input | ADDR_W | Word address of the transfer |
| bus_wdata | input | DATA_W | Data carried by a device-to-memory transfer |
| wb_mode | input | 1 | 1: cache is write-back, 0: write-through |
| fill_valid | input | 1 | Processor side fills a line |
| fill_addr | input | ADDR_W | Word address of the filled line |
| pinv_valid | input | 1 | Processor side invalidates a line |
| pinv_idx | input | IDX_W | Index of the line the processor invalidates |
| cpu_wr_valid | input | 1 | Processor write hit this cycle |
| cpu_wr_idx | input | IDX_W | Index of the processor write |
| cpu_stall | output | 1 | Processor write must wait one cycle |
| line_rd_idx | output | IDX_W | Index at which the cache presents line data |
| line_rd_data | input | DATA_W | Cache line data at `line_rd_idx` |
| inv_valid | output | 1 | Invalidate the line at `cmd_idx` |
| upd_valid | output | 1 | Write `upd_data` into the line at `cmd_idx` |
| cmd_idx | output | IDX_W | Line index of the command |
| upd_data | output | DATA_W | Data for an update command |
| mem_inhibit | output | 1 | Memory must not answer; the cache drives the data |
| supply_data | output | DATA_W | Line data the cache places on the bus |

## Verification
The assertions check several rules on every cycle. An update command only follows a device-to-memory transfer, the inhibit only appears together with an invalidate in write-back mode, an idle bus stays quiet, and a stall always has a matching command. They also check that a snoop invalidate clears the duplicate entry at the next cycle unless a same-index fill overrides it, and that a fill always lands. Some properties depend on history in the duplicate tags and only the bench's scenarios can show them. These are whether a hit or a miss is correct for a given tag, that a line stays resident after an update, that it is gone after an outgoing hit, and that the fill wins a same-cycle conflict. The bench sweeps every address, direction, mode and residency.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

    typedef enum logic {
        XFER_IN  = 1'b0,
        XFER_OUT = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic inv;
        logic upd;
        logic inhibit;
    } snoop_act_t;

endpackage

// File: rtl/snoop_tag_store.sv
module snoop_tag_store #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx,
    output logic             look_valid,
    output logic [TAG_W-1:0] look_tag,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             pinv_en,
    input  logic [IDX_W-1:0] pinv_idx,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag
);
    localparam int LINES = 1 << IDX_W;

    typedef struct packed {
        logic [LINES-1:0]            valid;
        logic [LINES-1:0][TAG_W-1:0] tag;
    } store_t;

    store_t st_d, st_q;

    // Order: snoop clear, then processor invalidate, then fill (fill wins).
    always_comb begin
        st_d = st_q;
        if (clr_en) begin
            st_d.valid[clr_idx] = 1'b0;
        end
        if (pinv_en) begin
            st_d.valid[pinv_idx] = 1'b0;
        end
        if (fill_en) begin
            st_d.valid[fill_idx] = 1'b1;
            st_d.tag[fill_idx]   = fill_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign look_valid = st_q.valid[look_idx];
    assign look_tag   = st_q.tag[look_idx];

    p_snoop_clear_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(fill_en && fill_idx == clr_idx)) |=> !st_q.valid[$past(clr_idx)]);

    p_fill_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (st_q.valid[$past(fill_idx)] && st_q.tag[$past(fill_idx)] == $past(fill_tag)));

    p_pinv_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pinv_en && !(fill_en && fill_idx == pinv_idx)) |=> !st_q.valid[$past(pinv_idx)]);

endmodule

// File: rtl/snoop_decide.sv
module snoop_decide
    import snoop_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic             bus_valid,
    input  xfer_dir_e        dir,
    input  logic             wb_mode,
    input  logic             entry_valid,
    input  logic [TAG_W-1:0] entry_tag,
    input  logic [TAG_W-1:0] bus_tag,
    output snoop_act_t       act
);
    logic hit;

    always_comb begin
        hit = bus_valid && entry_valid && (entry_tag == bus_tag);
        act = '0;
        if (hit) begin
            if (dir == XFER_IN) begin
                act.upd = 1'b1;
            end else begin
                act.inv     = 1'b1;
                act.inhibit = wb_mode;
            end
        end
    end

endmodule

// File: rtl/snoop_io_coherence.sv
module snoop_io_coherence
    import snoop_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_dir,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              wb_mode,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              pinv_valid,
    input  logic [IDX_W-1:0]  pinv_idx,
    input  logic              cpu_wr_valid,
    input  logic [IDX_W-1:0]  cpu_wr_idx,
    output logic              cpu_stall,
    output logic [IDX_W-1:0]  line_rd_idx,
    input  logic [DATA_W-1:0] line_rd_data,
    output logic              inv_valid,
    output logic              upd_valid,
    output logic [IDX_W-1:0]  cmd_idx,
    output logic [DATA_W-1:0] upd_data,
    output logic              mem_inhibit,
    output logic [DATA_W-1:0] supply_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] bus_idx;
    logic [TAG_W-1:0] bus_tag;
    logic             ent_valid;
    logic [TAG_W-1:0] ent_tag;
    snoop_act_t       act;

    assign bus_idx = bus_addr[IDX_W-1:0];
    assign bus_tag = bus_addr[ADDR_W-1:IDX_W];

    snoop_tag_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) tags_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_idx   (bus_idx),
        .look_valid (ent_valid),
        .look_tag   (ent_tag),
        .clr_en     (act.inv),
        .clr_idx    (bus_idx),
        .pinv_en    (pinv_valid),
        .pinv_idx   (pinv_idx),
        .fill_en    (fill_valid),
        .fill_idx   (fill_addr[IDX_W-1:0]),
        .fill_tag   (fill_addr[ADDR_W-1:IDX_W])
    );

    snoop_decide #(
        .TAG_W (TAG_W)
    ) decide_i (
        .bus_valid   (bus_valid),
        .dir         (xfer_dir_e'(bus_dir)),
        .wb_mode     (wb_mode),
        .entry_valid (ent_valid),
        .entry_tag   (ent_tag),
        .bus_tag     (bus_tag),
        .act         (act)
    );

    assign line_rd_idx = bus_idx;
    assign cmd_idx     = bus_idx;
    assign inv_valid   = act.inv;
    assign upd_valid   = act.upd;
    assign mem_inhibit = act.inhibit;
    assign upd_data    = act.upd ? bus_wdata : '0;
    assign supply_data = act.inhibit ? line_rd_data : '0;
    assign cpu_stall   = cpu_wr_valid && (act.inv || act.upd) && (cpu_wr_idx == bus_idx);

    p_upd_input_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (bus_valid && !bus_dir && !inv_valid && !mem_inhibit));

    p_inhibit_wb_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_inhibit |-> (bus_valid && bus_dir && wb_mode && inv_valid));

    p_wt_no_inhibit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !wb_mode) |-> (!mem_inhibit && supply_data == '0));

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (!inv_valid && !upd_valid && !mem_inhibit));

    p_stall_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> (cpu_wr_valid && (inv_valid || upd_valid) && cmd_idx == cpu_wr_idx));

endmodule

// File: tb/snoop_io_coherence_tb_top.sv
module snoop_io_coherence_tb_top;
    localparam int AW = 6;
    localparam int IW = 2;
    localparam int DW = 16;
    localparam int TW = AW - IW;
    localparam int NL = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_valid, bus_dir, wb_mode;
    logic [AW-1:0] bus_addr, fill_addr;
    logic [DW-1:0] bus_wdata;
    logic          fill_valid, pinv_valid, cpu_wr_valid;
    logic [IW-1:0] pinv_idx, cpu_wr_idx;
    logic          cpu_stall, inv_valid, upd_valid, mem_inhibit;
    logic [IW-1:0] line_rd_idx, cmd_idx;
    logic [DW-1:0] line_rd_data, upd_data, supply_data;

    always #2 clk = ~clk;

    function automatic logic [DW-1:0] pat(input logic [IW-1:0] i);
        return 16'hA000 + (16'(i) * 16'h0111);
    endfunction

    assign line_rd_data = pat(line_rd_idx);

    snoop_io_coherence #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_dir(bus_dir),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .wb_mode(wb_mode),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .pinv_valid(pinv_valid),
        .pinv_idx(pinv_idx), .cpu_wr_valid(cpu_wr_valid), .cpu_wr_idx(cpu_wr_idx),
        .cpu_stall(cpu_stall), .line_rd_idx(line_rd_idx), .line_rd_data(line_rd_data),
        .inv_valid(inv_valid), .upd_valid(upd_valid), .cmd_idx(cmd_idx),
        .upd_data(upd_data), .mem_inhibit(mem_inhibit), .supply_data(supply_data)
    );

    logic          mv [NL];
    logic [TW-1:0] mt [NL];
    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    task automatic chk(input string rq, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic cyc(input logic bv, input logic dir, input logic wb, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic fv, input logic [AW-1:0] fa,
                       input logic pv, input logic [IW-1:0] pi, input logic cv,
                       input logic [IW-1:0] ci, input string rq);
        logic [IW-1:0] idx;
        logic [TW-1:0] tg;
        logic hit, e_upd, e_inv, e_inh, e_stall;
        string lb;
        bus_valid = bv; bus_dir = dir; wb_mode = wb; bus_addr = a; bus_wdata = d;
        fill_valid = fv; fill_addr = fa; pinv_valid = pv; pinv_idx = pi;
        cpu_wr_valid = cv; cpu_wr_idx = ci;
        #1;
        idx = a[IW-1:0];
        tg  = a[AW-1:IW];
        hit = bv && mv[idx] && (mt[idx] == tg);
        e_upd = hit && !dir;
        e_inv = hit && dir;
        e_inh = e_inv && wb;
        e_stall = cv && (e_upd || e_inv) && (ci == idx);
        if (rq != "") lb = rq;
        else if (!hit) lb = "R6";
        else if (!dir) lb = "R3";
        else if (wb) lb = "R5";
        else lb = "R4";
        chk(lb, "upd_valid", int'(upd_valid), int'(e_upd));
        chk(lb, "inv_valid", int'(inv_valid), int'(e_inv));
        chk(lb, "mem_inhibit", int'(mem_inhibit), int'(e_inh));
        chk(lb, "supply_data", int'(supply_data), e_inh ? int'(pat(idx)) : 0);
        chk(lb, "upd_data", int'(upd_data), e_upd ? int'(d) : 0);
        chk("R5", "line_rd_idx", int'(line_rd_idx), int'(idx));
        if (hit) chk("R3", "cmd_idx", int'(cmd_idx), int'(idx));
        chk("R9", "cpu_stall", int'(cpu_stall), int'(e_stall));
        @(posedge clk);
        if (e_inv) mv[idx] = 1'b0;
        if (pv) mv[pi] = 1'b0;
        if (fv) begin
            mv[fa[IW-1:0]] = 1'b1;
            mt[fa[IW-1:0]] = fa[AW-1:IW];
        end
        @(negedge clk);
    endtask

    task automatic snoop(input logic dir, input logic wb, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic cv, input logic [IW-1:0] ci,
                         input string rq);
        cyc(1'b1, dir, wb, a, d, 1'b0, '0, 1'b0, '0, cv, ci, rq);
    endtask

    task automatic fill(input logic [AW-1:0] a);
        cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b1, a, 1'b0, '0, 1'b0, '0, "R2");
    endtask

    initial begin
        for (int i = 0; i < NL; i++) begin
            mv[i] = 1'b0;
            mt[i] = '0;
        end
        rst_n = 1'b0;
        bus_valid = 0; bus_dir = 0; wb_mode = 0; bus_addr = '0; bus_wdata = '0;
        fill_valid = 0; fill_addr = '0; pinv_valid = 0; pinv_idx = '0;
        cpu_wr_valid = 0; cpu_wr_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, every address misses in both directions and modes
        cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0, "R1");
        for (int a = 0; a < (1 << AW); a++) begin
            for (int dr = 0; dr < 2; dr++) begin
                snoop(dr[0], a[0], AW'(a), DW'(a * 37), 1'b1, AW'(a) & IW'(3), "R1");
            end
        end
        // R2: fills make entries resident
        for (int i = 0; i < NL; i++) fill(AW'(((i + 5) << IW) | i));
        for (int i = 0; i < NL; i++)
            snoop(1'b0, 1'b1, AW'(((i + 5) << IW) | i), DW'(16'h1234 + i), 1'b0, '0, "R2");
        // Sweep: every address, direction, mode, resident or not; repeat for R7
        for (int a = 0; a < (1 << AW); a++) begin
            for (int dr = 0; dr < 2; dr++) begin
                for (int wb = 0; wb < 2; wb++) begin
                    for (int h = 0; h < 2; h++) begin
                        logic [AW-1:0] aa;
                        aa = AW'(a);
                        if (h == 1) fill(aa);
                        snoop(dr[0], wb[0], aa, DW'(a * 257 + dr * 3 + wb), (a % 3) != 0,
                              IW'(a + h), "");
                        snoop(dr[0], wb[0], aa, DW'(a * 11 + 7), 1'b1, IW'(a), "R7");
                    end
                end
            end
        end
        // R8: processor invalidate
        fill(AW'(5));
        snoop(1'b0, 1'b0, AW'(5), 16'h0055, 1'b0, '0, "R8");
        cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b1, IW'(1), 1'b0, '0, "R8");
        snoop(1'b0, 1'b0, AW'(5), 16'h0056, 1'b0, '0, "R8");
        snoop(1'b1, 1'b1, AW'(5), 16'h0057, 1'b0, '0, "R8");
        // R10: fill and snoop invalidate on the same index in one cycle
        fill(AW'(6));
        cyc(1'b1, 1'b1, 1'b1, AW'(6), '0, 1'b1, AW'(34), 1'b0, '0, 1'b1, IW'(2), "R10");
        snoop(1'b0, 1'b0, AW'(34), 16'hBEEF, 1'b1, IW'(2), "R10");
        snoop(1'b0, 1'b0, AW'(6), 16'hCAFE, 1'b0, '0, "R10");
        snoop(1'b1, 1'b0, AW'(34), 16'h0000, 1'b0, '0, "R10");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule